// File: doc/BRIEF.md
# USB IN-Endpoint Transmit Buffer

This block is the transmit-side byte buffer for a single IN endpoint of a USB device. A producer (software or a DMA engine) pushes bytes one at a time through a write-data port. The block raises a ready level whenever it has room for another byte. The bytes wait in the buffer until the host asks this endpoint for data. The block then streams one packet to the link layer and ends it with an end-of-packet strobe. If no packet is ready, it answers with a one-cycle not-ready strobe.

A packet becomes ready in two cases: enough bytes have gathered to fill a maximum-size packet, or the producer has written the end-of-data request. With the end-of-data request pending and the buffer empty, the packet is zero bytes long.

For bulk, interrupt and control endpoints, the block keeps the packet after sending it and waits for the link to report whether the host acknowledged it:
- On an acknowledge, the packet's bytes are released.
- On a missed acknowledge, the send pointer rewinds so that the same bytes go out again.

Isochronous endpoints expect no handshake, so their packets are released at once. Every completed packet sets a sticky done interrupt, which is cleared by writing one. A status bit records the acknowledge result. A flush command empties the buffer, drops any pending end-of-data request and aborts a transfer in progress, without raising the interrupt.

Top module: `ep_tx_fifo`

## Requirements
- R1: `wr_ready` is high exactly while fewer than DEPTH unreleased bytes are stored. A write presented while `wr_ready` is low is dropped and never reaches the link.
- R2: A packet is ready when the unreleased byte count is at least MPS, or when an end-of-data request is pending. An `in_req` with no ready packet produces a one-cycle `tx_nak` in the following cycle and no `tx_valid`.
- R3: On an `in_req` with a ready packet, `tx_valid` rises in the next cycle. The packet carries min(count, MPS) bytes in write order, one per cycle in which `tx_rdy` is high. While `tx_rdy` is low, `tx_valid` and `tx_data` hold.
- R4: `tx_eop` pulses for one cycle after the last byte is taken, and never together with `tx_valid`. A zero-length packet shows only `tx_eop`.
- R5: For a non-isochronous endpoint (`is_iso` low), the block waits after `tx_eop` for `hs_ack` or `hs_miss`. On `hs_ack` it sets `done_irq`, sets `ack_ok` to 1 and releases the packet's bytes, one cycle after the handshake.
- R6: On `hs_miss`, the block sets `done_irq`, clears `ack_ok` and keeps the bytes, so the next ready `in_req` resends the identical packet.
- R7: With `is_iso` high, there is no handshake wait. One cycle after `tx_eop`, `done_irq` is set, `ack_ok` reads 0 and the bytes are released.
- R8: `flush` empties the buffer, clears a pending end-of-data request and returns the transmitter to idle, without setting `done_irq`.
- R9: `done_irq` stays set until `done_clr` is pulsed. A completion in the same cycle as `done_clr` leaves it set.
- R10: A pending end-of-data request is consumed when a packet shorter than MPS completes. If the request is pending when a full MPS packet completes, the next packet is zero bytes long.
- R11: After reset, `wr_ready` is 1 and `tx_valid`, `tx_eop`, `tx_nak`, `done_irq` and `ack_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer writes a byte this cycle |
| wr_data | input | 8 | Byte written by the producer |
| wr_ready | output | 1 | Buffer can accept a write |
| eod_wr | input | 1 | End-of-data request (write of one) |
| flush | input | 1 | Empty the buffer and abort |
| is_iso | input | 1 | Endpoint is isochronous |
| in_req | input | 1 | Host requests data from this endpoint |
| tx_rdy | input | 1 | Link takes the presented byte |
| tx_valid | output | 1 | A packet byte is presented |
| tx_data | output | 8 | Packet byte |
| tx_eop | output | 1 | End of packet strobe |
| tx_nak | output | 1 | No packet ready for the request |
| hs_ack | input | 1 | Host acknowledged the last packet |
| hs_miss | input | 1 | Host did not acknowledge the last packet |
| done_clr | input | 1 | Clear the done interrupt |
| done_irq | output | 1 | Sticky packet-complete interrupt |
| ack_ok | output | 1 | Last packet was acknowledged |

## Verification
The bench builds the block with DEPTH 8 and MPS 4, so the buffer holds exactly two maximum-size packets. That brings the full condition and dropped writes within reach after eight writes. Full packets, short packets that need an end-of-data request, zero-length packets, and a full packet followed by a zero-length terminator all fit in a few cycles. These values also let a missed acknowledge be retried while a second packet is already queued behind it.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_EOP  = 2'd2,
    ST_WAIT = 2'd3
  } tx_state_e;

  // distance between two wrapping pointers that count over span values
  function automatic int unsigned ptr_gap(int unsigned w, int unsigned b,
                                          int unsigned span);
    return (w + span - b) % span;
  endfunction

  // bytes carried by the next packet
  function automatic int unsigned pkt_size(int unsigned lvl, int unsigned mps);
    return (lvl < mps) ? lvl : mps;
  endfunction

  // a packet may leave once it is full or the producer closed it
  function automatic logic pkt_ready(int unsigned lvl, int unsigned mps,
                                     logic eod);
    return (lvl >= mps) || eod;
  endfunction

endpackage

// File: rtl/ep_tx_store.sv
module ep_tx_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ep_tx_ptrs.sv
module ep_tx_ptrs
  import ep_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_push,
  input  logic          rd_step,
  input  logic          commit,
  input  logic          rewind,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] level,
  output logic          full
);
  localparam int SPAN = 2 * DEPTH;
  localparam logic [PW-1:0] DEPTH_C = PW'(DEPTH);

  logic [PW-1:0] base_ptr;

  assign level = PW'(ptr_gap(32'(wr_ptr), 32'(base_ptr), SPAN));
  assign full  = (level == DEPTH_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      base_ptr <= '0;
    end else if (flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      base_ptr <= '0;
    end else begin
      if (wr_push) wr_ptr <= wr_ptr + 1'b1;
      if (rd_step)      rd_ptr <= rd_ptr + 1'b1;
      else if (rewind)  rd_ptr <= base_ptr;
      if (commit) base_ptr <= rd_ptr;
    end
  end
endmodule

// File: rtl/ep_tx_seq.sv
module ep_tx_seq
  import ep_tx_pkg::*;
#(
  parameter int MPS = 8,
  parameter int PW  = 5,
  parameter int CW  = $clog2(MPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          eod_wr,
  input  logic          is_iso,
  input  logic          in_req,
  input  logic          tx_rdy,
  input  logic          hs_ack,
  input  logic          hs_miss,
  input  logic          done_clr,
  input  logic [PW-1:0] level,
  output logic          tx_valid,
  output logic          tx_eop,
  output logic          tx_nak,
  output logic          rd_step,
  output logic          commit,
  output logic          rewind,
  output logic          done_set,
  output logic          done_irq,
  output logic          ack_ok
);
  localparam logic [CW-1:0] MPS_C = CW'(MPS);

  tx_state_e     state;
  logic [CW-1:0] pkt_len;
  logic [CW-1:0] sent;
  logic          eod_pend;
  logic          nak_q;
  logic          eligible;
  logic          start;
  logic [CW-1:0] next_len;

  assign eligible = pkt_ready(32'(level), MPS, eod_pend);
  assign start    = (state == ST_IDLE) && in_req && eligible;
  assign next_len = CW'(pkt_size(32'(level), MPS));

  assign tx_valid = (state == ST_SEND);
  assign tx_eop   = (state == ST_EOP);
  assign tx_nak   = nak_q;

  assign rd_step  = !flush && (state == ST_SEND) && tx_rdy;
  assign commit   = !flush && (((state == ST_EOP) && is_iso) ||
                               ((state == ST_WAIT) && hs_ack));
  assign rewind   = !flush && (state == ST_WAIT) && !hs_ack && hs_miss;
  assign done_set = commit || rewind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pkt_len  <= '0;
      sent     <= '0;
      eod_pend <= 1'b0;
      nak_q    <= 1'b0;
    end else if (flush) begin
      state    <= ST_IDLE;
      sent     <= '0;
      eod_pend <= 1'b0;
      nak_q    <= 1'b0;
    end else begin
      nak_q <= (state == ST_IDLE) && in_req && !eligible;
      if (commit && (pkt_len < MPS_C)) eod_pend <= 1'b0;
      if (eod_wr)                      eod_pend <= 1'b1;
      unique case (state)
        ST_IDLE: if (start) begin
          pkt_len <= next_len;
          sent    <= '0;
          state   <= (next_len == '0) ? ST_EOP : ST_SEND;
        end
        ST_SEND: if (tx_rdy) begin
          sent <= sent + 1'b1;
          if (sent == pkt_len - 1'b1) state <= ST_EOP;
        end
        ST_EOP:  state <= is_iso ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (hs_ack || hs_miss) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_irq <= 1'b0;
      ack_ok   <= 1'b0;
    end else begin
      if (done_set)      done_irq <= 1'b1;
      else if (done_clr) done_irq <= 1'b0;
      if (commit)        ack_ok <= !is_iso;
      else if (rewind)   ack_ok <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_tx_fifo.sv
module ep_tx_fifo
  import ep_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int MPS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  input  logic       eod_wr,
  input  logic       flush,
  input  logic       is_iso,
  input  logic       in_req,
  input  logic       tx_rdy,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_eop,
  output logic       tx_nak,
  input  logic       hs_ack,
  input  logic       hs_miss,
  input  logic       done_clr,
  output logic       done_irq,
  output logic       ack_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // named internal events, visible to the bound checker
  logic          wr_accept;
  logic          rd_step;
  logic          commit;
  logic          rewind;
  logic          done_set;
  logic          full;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] level;

  assign wr_ready  = !full;
  assign wr_accept = wr_valid && !full && !flush;

  ep_tx_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_accept),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (wr_data),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (tx_data)
  );

  ep_tx_ptrs #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_push (wr_accept),
    .rd_step (rd_step),
    .commit  (commit),
    .rewind  (rewind),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .level   (level),
    .full    (full)
  );

  ep_tx_seq #(.MPS(MPS), .PW(PW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .eod_wr   (eod_wr),
    .is_iso   (is_iso),
    .in_req   (in_req),
    .tx_rdy   (tx_rdy),
    .hs_ack   (hs_ack),
    .hs_miss  (hs_miss),
    .done_clr (done_clr),
    .level    (level),
    .tx_valid (tx_valid),
    .tx_eop   (tx_eop),
    .tx_nak   (tx_nak),
    .rd_step  (rd_step),
    .commit   (commit),
    .rewind   (rewind),
    .done_set (done_set),
    .done_irq (done_irq),
    .ack_ok   (ack_ok)
  );
endmodule

// File: rtl/ep_tx_fifo_chk.sv
module ep_tx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          is_iso,
  input logic          tx_rdy,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_eop,
  input logic          tx_nak,
  input logic          done_clr,
  input logic          done_irq,
  input logic          ack_ok,
  input logic          wr_ready,
  input logic          done_set,
  input logic [PW-1:0] level
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PW'(DEPTH)); // R1

  AST_NAK_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nak |-> !tx_valid); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_rdy && !flush) |=> (tx_valid && $stable(tx_data))); // R3

  AST_EOP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eop |-> !tx_valid); // R4

  AST_ISO_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (is_iso && done_set) |=> !ack_ok); // R7

  AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_ready && !tx_valid && !tx_eop)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !done_clr) |=> done_irq); // R9
endmodule

bind ep_tx_fifo ep_tx_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .is_iso   (is_iso),
  .tx_rdy   (tx_rdy),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .tx_eop   (tx_eop),
  .tx_nak   (tx_nak),
  .done_clr (done_clr),
  .done_irq (done_irq),
  .ack_ok   (ack_ok),
  .wr_ready (wr_ready),
  .done_set (done_set),
  .level    (level)
);

// File: tb/ep_tx_fifo_bench.sv
module ep_tx_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int MPS   = 4;
  localparam int NVEC  = 8;

  // vector: [11:8] bytes written, [7] end-of-data, [6:5] handshake (0 ack,1 miss,2 iso),
  //         [4:1] expected packet length, [0] expected not-ready answer
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd4, 1'b0, 2'd0, 4'd4, 1'b0},
    {4'd2, 1'b1, 2'd0, 4'd2, 1'b0},
    {4'd2, 1'b0, 2'd0, 4'd0, 1'b1},
    {4'd0, 1'b1, 2'd0, 4'd0, 1'b0},
    {4'd6, 1'b0, 2'd1, 4'd4, 1'b0},
    {4'd3, 1'b1, 2'd2, 4'd3, 1'b0},
    {4'd8, 1'b0, 2'd2, 4'd4, 1'b0},
    {4'd1, 1'b1, 2'd1, 4'd1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, eod_wr = 1'b0, flush = 1'b0, is_iso = 1'b0;
  logic in_req = 1'b0, tx_rdy = 1'b0, hs_ack = 1'b0, hs_miss = 1'b0, done_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, tx_valid, tx_eop, tx_nak, done_irq, ack_ok;
  logic [7:0] tx_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] got [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_tx_fifo #(.DEPTH(DEPTH), .MPS(MPS)) u_ep_tx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .eod_wr(eod_wr), .flush(flush), .is_iso(is_iso),
    .in_req(in_req), .tx_rdy(tx_rdy), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_eop(tx_eop), .tx_nak(tx_nak), .hs_ack(hs_ack), .hs_miss(hs_miss),
    .done_clr(done_clr), .done_irq(done_irq), .ack_ok(ack_ok)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d; tick(); wr_valid = 1'b0;
  endtask

  task automatic pulse_eod();
    eod_wr = 1'b1; tick(); eod_wr = 1'b0;
  endtask

  task automatic pulse_flush();
    flush = 1'b1; tick(); flush = 1'b0;
  endtask

  task automatic pulse_clr();
    done_clr = 1'b1; tick(); done_clr = 1'b0;
  endtask

  task automatic receive(input bit req, output int n, output bit eop, output bit nak);
    n = 0; eop = 1'b0; nak = 1'b0; tx_rdy = 1'b1;
    if (req) begin in_req = 1'b1; tick(); in_req = 1'b0; end
    for (int c = 0; c < 24; c++) begin
      if (tx_nak) begin nak = 1'b1; break; end
      if (tx_eop) begin eop = 1'b1; break; end
      if (tx_valid && n < 16) begin got[n] = tx_data; n++; end
      tick();
    end
  endtask

  // kind 0 ack, 1 miss, 2 isochronous (no handshake)
  task automatic handshake(input int kind, input bit clr_too);
    tick();
    if (kind != 2) begin
      hs_ack = (kind == 0); hs_miss = (kind == 1); done_clr = clr_too;
      tick();
      hs_ack = 1'b0; hs_miss = 1'b0; done_clr = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int n;
    bit eop, nak;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R11 reset state
    chk("R11 wr_ready", int'(wr_ready), 1);
    chk("R11 tx_valid", int'(tx_valid), 0);
    chk("R11 tx_eop", int'(tx_eop), 0);
    chk("R11 tx_nak", int'(tx_nak), 0);
    chk("R11 done_irq", int'(done_irq), 0);
    chk("R11 ack_ok", int'(ack_ok), 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      int nb, kind, elen;
      bit eod, enak;
      nb = int'(VEC[k][11:8]); eod = VEC[k][7]; kind = int'(VEC[k][6:5]);
      elen = int'(VEC[k][4:1]); enak = VEC[k][0];
      pulse_flush();
      pulse_clr();
      is_iso = (kind == 2);
      for (int i = 0; i < nb; i++) put(8'(k * 16 + i));
      if (eod) pulse_eod();
      receive(1'b1, n, eop, nak);
      chk("R2 nak answer", int'(nak), int'(enak));
      chk("R3 packet length", n, elen);
      for (int i = 0; i < n; i++) chk("R3 byte order", int'(got[i]), k * 16 + i);
      if (!enak) begin
        chk("R4 end of packet", int'(eop), 1);
        handshake(kind, 1'b0);
        chk("R5 R6 R7 done set", int'(done_irq), 1);
        chk("R5 R6 R7 ack status", int'(ack_ok), (kind == 0) ? 1 : 0);
      end else begin
        chk("R2 no done on nak", int'(done_irq), 0);
      end
      is_iso = 1'b0;
    end

    // R1 full buffer drops writes
    pulse_flush();
    for (int i = 0; i < 10; i++) put(8'(8'hA0 + i));
    chk("R1 full", int'(wr_ready), 0);
    receive(1'b1, n, eop, nak);
    handshake(0, 1'b0);
    chk("R1 space after ack", int'(wr_ready), 1);
    receive(1'b1, n, eop, nak);
    chk("R1 second packet length", n, 4);
    chk("R1 last kept byte", int'(got[3]), 8'hA7);
    handshake(0, 1'b0);
    receive(1'b1, n, eop, nak);
    chk("R1 dropped bytes never sent", int'(nak), 1);

    // R6 retry after missed acknowledge
    pulse_flush();
    for (int i = 0; i < 4; i++) put(8'(8'h50 + i));
    receive(1'b1, n, eop, nak);
    handshake(1, 1'b0);
    chk("R6 ack_ok after miss", int'(ack_ok), 0);
    receive(1'b1, n, eop, nak);
    chk("R6 resend length", n, 4);
    chk("R6 resend first byte", int'(got[0]), 8'h50);
    chk("R6 resend last byte", int'(got[3]), 8'h53);
    handshake(0, 1'b0);
    chk("R5 ack_ok after ack", int'(ack_ok), 1);

    // R10 full packet with end-of-data leaves a zero-length terminator
    pulse_flush();
    for (int i = 0; i < 4; i++) put(8'(8'h60 + i));
    pulse_eod();
    receive(1'b1, n, eop, nak);
    chk("R10 full packet", n, 4);
    handshake(0, 1'b0);
    receive(1'b1, n, eop, nak);
    chk("R10 terminator length", n, 0);
    chk("R10 terminator eop", int'(eop), 1);
    handshake(0, 1'b0);
    receive(1'b1, n, eop, nak);
    chk("R10 request consumed", int'(nak), 1);

    // R9 sticky done, clear, and set winning over clear
    chk("R9 done held", int'(done_irq), 1);
    tick();
    chk("R9 done still held", int'(done_irq), 1);
    pulse_clr();
    chk("R9 done cleared", int'(done_irq), 0);
    for (int i = 0; i < 4; i++) put(8'(i));
    receive(1'b1, n, eop, nak);
    handshake(0, 1'b1);
    chk("R9 set beats clear", int'(done_irq), 1);
    pulse_clr();

    // R8 flush drops data and end-of-data request
    for (int i = 0; i < 3; i++) put(8'(i));
    pulse_eod();
    pulse_flush();
    chk("R8 empty after flush", int'(wr_ready), 1);
    receive(1'b1, n, eop, nak);
    chk("R8 request dropped", int'(nak), 1);
    // R8 flush in the middle of a packet
    for (int i = 0; i < 4; i++) put(8'(i));
    tx_rdy = 1'b0; in_req = 1'b1; tick(); in_req = 1'b0;
    chk("R3 valid after request", int'(tx_valid), 1);
    pulse_flush();
    chk("R8 send aborted", int'(tx_valid), 0);
    tick();
    chk("R8 no eop after flush", int'(tx_eop), 0);
    chk("R8 no done after flush", int'(done_irq), 0);

    // R3 stall holds the byte
    for (int i = 0; i < 4; i++) put(8'(8'h30 + i));
    tx_rdy = 1'b0; in_req = 1'b1; tick(); in_req = 1'b0;
    tick(); tick();
    chk("R3 stall valid", int'(tx_valid), 1);
    chk("R3 stall data", int'(tx_data), 8'h30);
    receive(1'b0, n, eop, nak);
    chk("R3 after stall length", n, 4);
    chk("R3 after stall last", int'(got[3]), 8'h33);
    handshake(0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule